// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block turns two asynchronous interrupt pins into interrupt requests. Each pin first passes through a synchroniser. A detector then watches the synchronised pin for the condition that its 2-bit sense field selects. Each request is gated by a per-channel mask bit and by a global interrupt enable before it leaves the block.

The sense field can select a low level, any change, a falling edge or a rising edge. The three edge-type modes latch a per-channel flag. Software clears a flag by writing a 1 to it, or a per-channel acknowledge input clears it. Low-level mode does not latch anything: its request follows the synchronised pin directly.

A small register port gives access to three registers:
- the sense control register;
- the mask register;
- the flag register.

The port writes in one cycle and reads combinationally.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset the control, mask and flag registers all read 0x00, both channels are in low-level mode, and `irq_o` is 0.
- R2: The control register sits at address 0. Bits 1:0 hold the channel 0 sense field and bits 3:2 hold the channel 1 sense field. Bits 7:4 always read zero, and writes to them are ignored.
- R3: The sense encoding is 00 for low level, 01 for any change, 10 for falling edge and 11 for rising edge. In the three edge-type modes, a matching pin transition driven before clock edge k raises the request after edge k+2 and no earlier.
- R4: In low-level mode the request is high exactly while the synchronised pin is low. A pin change before edge k shows on the request after edge k+1. Low-level mode leaves the flag untouched.
- R5: `irq_o[c]` is high only when `gie_i` is 1 and mask bit c is 1. The mask register sits at address 1, with bit c for channel c and bits 7:2 reading zero. Gating is combinational.
- R6: An edge-type event sets flag c even while the channel is masked. The flag holds until it is cleared, so the request appears as soon as the mask bit is set.
- R7: The flag register sits at address 2, with bit c for channel c and bits 7:2 reading zero. Writing a 1 to a bit clears that flag. Writing a 0 leaves it unchanged.
- R8: A one-cycle pulse on `ack_i[c]` clears flag c.
- R9: If an event and a clear (acknowledge or write-1) hit the same flag in the same cycle, the flag ends up set.
- R10: Changing a channel's sense mode while its pin is steady never sets its flag.
- R11: In edge-type modes, a pin pulse one clock period long sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 2 | Asynchronous interrupt pins, bit c for channel c |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 2 | Per-channel flag acknowledge |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 control, 1 mask, 2 flag |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| irq_o | output | 2 | Gated interrupt requests |

## Verification
Pins change at a falling clock edge. A level-mode request is due two rising edges later, because it passes two synchroniser flops. An edge-mode request is due three rising edges later, because the flag register adds one more flop. The bench checks one edge before each due point and again at it. Register writes take effect at the next rising edge, while mask and enable gating act in the same cycle. The bench therefore samples at the following falling edge for writes, and 1 ns after the change for gating. The same-cycle set/clear case raises the acknowledge at the falling edge right after the second synchroniser edge, so the acknowledge and the detected event meet at the same rising edge.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int NUM_CH  = 2;
  localparam int SENSE_W = 2;
  localparam int REG_W   = 8;
  localparam int ADDR_W  = 2;

  typedef enum logic [SENSE_W-1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_FLAG = 2'd2;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sq;

  // idle-high pins: reset to 1 so no level request leaves reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sq <= '1;
    else         sq <= {sq[STAGES-2:0], d_i};
  end

  assign q_o = sq[STAGES-1];
endmodule

// File: rtl/ext_irq_chan.sv
module ext_irq_chan
  import ext_irq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  sense_e mode_i,
  input  logic   lvl_i,
  input  logic   clr_i,
  output logic   evt_o,
  output logic   flag_o,
  output logic   req_o
);
  logic prev_q, flag_q, rise, fall;

  // previous sample runs in every mode: a mode switch sees no edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= lvl_i;
  end

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;

  always_comb begin
    unique case (mode_i)
      SENSE_ANY:  evt_o = rise | fall;
      SENSE_FALL: evt_o = fall;
      SENSE_RISE: evt_o = rise;
      default:    evt_o = 1'b0;
    endcase
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (evt_o)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign req_o  = (mode_i == SENSE_LOW) ? ~lvl_i : flag_q;
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import ext_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] pin_i,
  input  logic              gie_i,
  input  logic [NUM_CH-1:0] ack_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic [NUM_CH-1:0] irq_o
);
  localparam int CTRL_W = NUM_CH * SENSE_W;

  logic [CTRL_W-1:0] ctrl_q;
  logic [NUM_CH-1:0] mask_q;
  logic [NUM_CH-1:0] sync_s, evt, flag_q, clr, req;
  logic              flag_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mask_q <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == ADDR_CTRL) ctrl_q <= reg_wdata_i[CTRL_W-1:0];
      if (reg_addr_i == ADDR_MASK) mask_q <= reg_wdata_i[NUM_CH-1:0];
    end
  end

  assign flag_wr = reg_we_i && (reg_addr_i == ADDR_FLAG);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign clr[c] = ack_i[c] | (flag_wr & reg_wdata_i[c]);

    ext_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (pin_i[c]),
      .q_o    (sync_s[c])
    );

    ext_irq_chan u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .mode_i (sense_e'(ctrl_q[c*SENSE_W +: SENSE_W])),
      .lvl_i  (sync_s[c]),
      .clr_i  (clr[c]),
      .evt_o  (evt[c]),
      .flag_o (flag_q[c]),
      .req_o  (req[c])
    );
  end

  assign irq_o = {NUM_CH{gie_i}} & mask_q & req;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_CTRL: reg_rdata_o[CTRL_W-1:0] = ctrl_q;
      ADDR_MASK: reg_rdata_o[NUM_CH-1:0] = mask_q;
      ADDR_FLAG: reg_rdata_o[NUM_CH-1:0] = flag_q;
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ext_irq_sense_chk.sv
module ext_irq_sense_chk
  import ext_irq_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  gie_i,
  input logic [NUM_CH-1:0]     mask_q,
  input logic [2*NUM_CH-1:0]   ctrl_q,
  input logic [NUM_CH-1:0]     sync_s,
  input logic [NUM_CH-1:0]     evt,
  input logic [NUM_CH-1:0]     flag_q,
  input logic [NUM_CH-1:0]     clr,
  input logic [NUM_CH-1:0]     irq_o,
  input logic [ADDR_W-1:0]     reg_addr_i,
  input logic [REG_W-1:0]      reg_rdata_o
);
  // R2
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADDR_CTRL) |-> (reg_rdata_o[REG_W-1:2*NUM_CH] == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R5
    gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[c] |-> (gie_i && mask_q[c]));
    // R6
    evt_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt[c] |=> flag_q[c]);
    // R6
    flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[c] && !clr[c]) |=> flag_q[c]);
    // R8
    clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr[c] && !evt[c]) |=> !flag_q[c]);
    // R4
    level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_q[2*c +: 2] == 2'b00 && irq_o[c]) |-> !sync_s[c]);
    // R10
    no_false_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt[c] |-> (sync_s[c] != $past(sync_s[c])));
  end
endmodule

bind ext_irq_sense ext_irq_sense_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .gie_i       (gie_i),
  .mask_q      (mask_q),
  .ctrl_q      (ctrl_q),
  .sync_s      (sync_s),
  .evt         (evt),
  .flag_q      (flag_q),
  .clr         (clr),
  .irq_o       (irq_o),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o)
);

// File: tb/ext_irq_sense_test.sv
module ext_irq_sense_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pin = 2'b11;
  logic       gie = 1'b0;
  logic [1:0] ack = 2'b00;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [1:0] irq;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ext_irq_sense uut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .gie_i(gie), .ack_i(ack),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  // {mode, pin before, pin after, expected irq0}
  localparam logic [4:0] VEC [8] = '{
    5'b00_1_0_1, 5'b00_0_1_0, 5'b01_0_1_1, 5'b01_1_0_1,
    5'b10_0_1_0, 5'b10_1_0_1, 5'b11_0_1_1, 5'b11_1_0_0
  };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick(1);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  initial begin
    logic [7:0] v;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1
    rd(2'd0, v); chk(v, 8'h00, "R1 ctrl");
    rd(2'd1, v); chk(v, 8'h00, "R1 mask");
    rd(2'd2, v); chk(v, 8'h00, "R1 flag");
    chk({6'd0, irq}, 8'h00, "R1 irq");
    // R2
    wr(2'd0, 8'hFF); rd(2'd0, v); chk(v, 8'h0F, "R2 rsvd");
    wr(2'd0, 8'h00);
    wr(2'd1, 8'hFF); rd(2'd1, v); chk(v, 8'h03, "R5 mask bits");
    gie = 1'b1;

    // R3 R4 table, channel 0
    for (int i = 0; i < 8; i++) begin
      wr(2'd0, {6'd0, VEC[i][4:3]});
      pin[0] = VEC[i][2];
      tick(4);
      wr(2'd2, 8'h03);
      pin[0] = VEC[i][1];
      tick(4);
      chk({7'd0, irq[0]}, {7'd0, VEC[i][0]}, $sformatf("R3 R4 vec %0d irq", i));
      rd(2'd2, v);
      chk(v, {7'd0, VEC[i][0] && (VEC[i][4:3] != 2'b00)}, $sformatf("R3 R4 vec %0d flag", i));
    end

    // R4 timing on channel 1
    wr(2'd0, 8'h00);
    pin[1] = 1'b0;
    tick(1); chk({7'd0, irq[1]}, 8'h00, "R4 early");
    tick(1); chk({7'd0, irq[1]}, 8'h01, "R4 due");
    pin[1] = 1'b1;
    tick(2); chk({7'd0, irq[1]}, 8'h00, "R4 release");
    rd(2'd2, v); chk(v, 8'h00, "R4 no flag");

    // R3 timing, channel 0 rising
    wr(2'd0, 8'h03); pin[0] = 1'b0; tick(4); wr(2'd2, 8'h03);
    pin[0] = 1'b1;
    tick(2); chk({7'd0, irq[0]}, 8'h00, "R3 early");
    tick(1); chk({7'd0, irq[0]}, 8'h01, "R3 due");

    // R5 gating
    gie = 1'b0; #1 chk({6'd0, irq}, 8'h00, "R5 gie off");
    @(negedge clk); gie = 1'b1;
    wr(2'd1, 8'h02); chk({7'd0, irq[0]}, 8'h00, "R5 masked");
    rd(2'd2, v); chk(v, 8'h01, "R6 held masked");

    // R6 event while masked
    wr(2'd2, 8'h03);
    wr(2'd0, 8'h02);
    pin[0] = 1'b0; tick(4);
    chk({7'd0, irq[0]}, 8'h00, "R6 masked irq");
    rd(2'd2, v); chk(v, 8'h01, "R6 flag masked");
    wr(2'd1, 8'h03); chk({7'd0, irq[0]}, 8'h01, "R6 unmask");

    // R7
    wr(2'd2, 8'h00); rd(2'd2, v); chk(v, 8'h01, "R7 write 0");
    wr(2'd2, 8'hFD); rd(2'd2, v); chk(v, 8'h00, "R7 write 1");
    chk({7'd0, irq[0]}, 8'h00, "R7 irq low");

    // R8
    wr(2'd0, 8'h01); pin[0] = 1'b1; tick(4);
    rd(2'd2, v); chk(v, 8'h01, "R8 set");
    ack = 2'b01; tick(1); ack = 2'b00;
    rd(2'd2, v); chk(v, 8'h00, "R8 ack");

    // R9 same-cycle set and clear
    pin[0] = 1'b0; tick(4);
    rd(2'd2, v); chk(v, 8'h01, "R9 pre");
    pin[0] = 1'b1; tick(2);
    ack = 2'b01; tick(1); ack = 2'b00;
    rd(2'd2, v); chk(v, 8'h01, "R9 set wins");

    // R10 mode switches with steady pin
    wr(2'd0, 8'h03); tick(4); wr(2'd2, 8'h03);
    wr(2'd0, 8'h02); tick(4);
    rd(2'd2, v); chk(v, 8'h00, "R10 rise to fall");
    wr(2'd0, 8'h00); pin[0] = 1'b0; tick(4);
    pin[0] = 1'b1; tick(4);
    wr(2'd0, 8'h03); tick(4);
    rd(2'd2, v); chk(v, 8'h00, "R10 low to rise");

    // R11 single-cycle pulse
    pin[0] = 1'b0; tick(4); wr(2'd2, 8'h03);
    pin[0] = 1'b1; tick(1); pin[0] = 1'b0; tick(4);
    rd(2'd2, v); chk(v, 8'h01, "R11 short pulse");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule